// File: doc/BRIEF.md
# USB Endpoint Interrupt Status Register

This block holds the sticky interrupt flags of a USB function controller that has one control endpoint (endpoint 0) and three data endpoints (1 to 3), each with an IN and an OUT direction. The endpoint logic reports events as single-cycle pulses (a packet sent or received without error) and as status levels (data-end, forced stall, setup-end, underrun, overrun). The block turns the level inputs into edge events, latches every event into its flag, and raises one registered interrupt request while any flag is pending.

Software reads the whole register over a small synchronous bus and clears individual flags by writing ones to them. A write can never set a flag. When an event and a clearing write land on the same flag in the same cycle, the event is kept.

Each implemented flag is a two-state machine. The states are `FLG_IDLE` (flag reads 0) and `FLG_PEND` (flag reads 1). The transitions are SET (`FLG_IDLE` to `FLG_PEND` on a set event), CLEAR (`FLG_PEND` to `FLG_IDLE` on a clearing write with no set event in the same cycle) and HOLD (every other case keeps the state).

Top module: `usb_ep_irq_status`

## Requirements
- R1: After reset, every flag is 0, `irq` is 0 and `bus_rdata` is 0.
- R2: Flag bit 0 (control endpoint) sets on an `ep0_rx_done` pulse, on an `ep0_tx_done` pulse, on a 1-to-0 change of `ep0_data_end`, on a 0-to-1 change of `ep0_stall`, or on a 0-to-1 change of `ep0_setup_end`.
- R3: Flag bits 2, 4 and 6 are the IN flags of endpoints 1, 2 and 3 (input index 0, 1, 2). Each sets on an `ep_tx_done` pulse for its endpoint or on a 0-to-1 change of that endpoint's `ep_underrun`.
- R4: Flag bits 3, 5 and 7 are the OUT flags of endpoints 1, 2 and 3. Each sets on an `ep_rx_done` pulse for its endpoint, or on a 0-to-1 change of that endpoint's `ep_overrun` or `ep_stall`.
- R5: A level input that stays steady never sets a flag, and a change in the opposite direction (0-to-1 of `ep0_data_end`, or 1-to-0 of any other level input) never sets a flag.
- R6: Bit 1 is unimplemented and always reads 0, whatever is written.
- R7: A write to address `REG_ADDR` (default 0x52) clears each flag whose `bus_wdata` bit is 1. Flags whose data bit is 0 keep their value, and no write sets a flag.
- R8: Writes and reads at any other address leave the flags unchanged, and such a read returns 0.
- R9: If a set event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R10: `irq` is a register holding the OR of all flags. It rises one cycle after the first flag sets and falls one cycle after the last flag clears.
- R11: A read strobe at `REG_ADDR` returns the flag values on `bus_rdata` one cycle later, and the read does not change any flag. `bus_rdata` is 0 in any cycle that does not follow such a read.
- R12: A flag sets at the clock edge that samples a pulse, and also at the first edge that samples a level input after its change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW (8) | Register address |
| bus_wdata | input | NF (8) | Write data; a 1 clears the flag at that bit |
| bus_rdata | output | NF (8) | Registered read data |
| irq | output | 1 | Interrupt request; OR of all flags, registered |
| ep0_rx_done | input | 1 | Pulse: control endpoint packet received |
| ep0_tx_done | input | 1 | Pulse: control endpoint packet sent |
| ep0_data_end | input | 1 | Level: control endpoint data-end bit |
| ep0_stall | input | 1 | Level: control endpoint force-stall bit |
| ep0_setup_end | input | 1 | Level: control endpoint setup-end bit |
| ep_tx_done | input | N_EP (3) | Pulses: data endpoint packet sent |
| ep_rx_done | input | N_EP (3) | Pulses: data endpoint packet received |
| ep_underrun | input | N_EP (3) | Levels: data endpoint underrun bits |
| ep_overrun | input | N_EP (3) | Levels: data endpoint overrun bits |
| ep_stall | input | N_EP (3) | Levels: data endpoint force-stall bits |

## Verification
A pulse or a level change driven before edge k sets its flag at edge k. `irq` follows at edge k+1. A read strobe presented before an edge returns data just after that edge, and a clearing write takes effect at the edge that samples it. The bench drives every input at a falling edge and samples one falling edge later. It checks `irq` both before and after the read that follows each event, so a flag or an `irq` that arrives a cycle early or late is reported. The bench covers every trigger source of every flag, the opposite edge and the held level of each level input, and the same-cycle collision of an event with a clearing write.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_PEND = 1'b1
    } flag_state_t;

endpackage

// File: rtl/usb_irq_edge.sv
module usb_irq_edge #(
    parameter int unsigned    W         = 1,
    parameter logic [W-1:0]   FALL_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] ev_o
);

    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= lvl_i;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (FALL_MASK[i]) begin : g_fall
            assign ev_o[i] = prev_q[i] & ~lvl_i[i];
        end else begin : g_rise
            assign ev_o[i] = lvl_i[i] & ~prev_q[i];
        end
    end

endmodule

// File: rtl/usb_irq_flag.sv
module usb_irq_flag
    import usb_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    flag_state_t st_q;
    flag_state_t st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= FLG_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // SET has priority over CLEAR so that no event is lost.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FLG_IDLE: if (set_i)           st_d = FLG_PEND;
            FLG_PEND: if (clr_i && !set_i) st_d = FLG_IDLE;
            default:                       st_d = FLG_IDLE;
        endcase
    end

    always_comb begin
        flag_o = (st_q == FLG_PEND);
    end

endmodule

// File: rtl/usb_irq_bus.sv
module usb_irq_bus #(
    parameter int unsigned     AW       = 8,
    parameter int unsigned     DW       = 8,
    parameter logic [AW-1:0]   REG_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] flags_i,
    output logic [DW-1:0] clr_mask_o,
    output logic [DW-1:0] rdata_o
);

    logic hit;

    assign hit        = (addr_i == REG_ADDR);
    assign clr_mask_o = (wr_i && hit) ? wdata_i : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (rd_i && hit) begin
            rdata_o <= flags_i;
        end else begin
            rdata_o <= '0;
        end
    end

endmodule

// File: rtl/usb_ep_irq_status.sv
module usb_ep_irq_status #(
    parameter int unsigned                 N_EP     = 3,
    parameter int unsigned                 AW       = 8,
    parameter logic [AW-1:0]               REG_ADDR = 8'h52,
    localparam int unsigned                NF       = 2 + 2 * N_EP
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [AW-1:0]   bus_addr,
    input  logic [NF-1:0]   bus_wdata,
    output logic [NF-1:0]   bus_rdata,
    output logic            irq,
    input  logic            ep0_rx_done,
    input  logic            ep0_tx_done,
    input  logic            ep0_data_end,
    input  logic            ep0_stall,
    input  logic            ep0_setup_end,
    input  logic [N_EP-1:0] ep_tx_done,
    input  logic [N_EP-1:0] ep_rx_done,
    input  logic [N_EP-1:0] ep_underrun,
    input  logic [N_EP-1:0] ep_overrun,
    input  logic [N_EP-1:0] ep_stall
);

    // Level vector: [0] data-end (falling), [1] ep0 stall, [2] setup-end,
    // then underrun, overrun, stall of each data endpoint (rising).
    localparam int unsigned    NL        = 3 + 3 * N_EP;
    localparam int unsigned    L_UND     = 3;
    localparam int unsigned    L_OVR     = 3 + N_EP;
    localparam int unsigned    L_STL     = 3 + 2 * N_EP;
    localparam logic [NL-1:0]  FALL_MASK = NL'(1);
    localparam logic [NF-1:0]  IMPL_MASK = ~(NF'(1) << 1);

    logic [NL-1:0] lvl;
    logic [NL-1:0] lvl_ev;
    logic [NF-1:0] set_ev;
    logic [NF-1:0] clr_mask;
    logic [NF-1:0] flags;

    assign lvl = {ep_stall, ep_overrun, ep_underrun, ep0_setup_end, ep0_stall, ep0_data_end};

    usb_irq_edge #(
        .W         (NL),
        .FALL_MASK (FALL_MASK)
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (lvl),
        .ev_o  (lvl_ev)
    );

    always_comb begin
        set_ev    = '0;
        set_ev[0] = ep0_rx_done | ep0_tx_done | lvl_ev[0] | lvl_ev[1] | lvl_ev[2];
        for (int e = 0; e < int'(N_EP); e++) begin
            set_ev[2 + 2*e] = ep_tx_done[e] | lvl_ev[L_UND + e];
            set_ev[3 + 2*e] = ep_rx_done[e] | lvl_ev[L_OVR + e] | lvl_ev[L_STL + e];
        end
    end

    usb_irq_bus #(
        .AW       (AW),
        .DW       (NF),
        .REG_ADDR (REG_ADDR)
    ) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (bus_wr),
        .rd_i       (bus_rd),
        .addr_i     (bus_addr),
        .wdata_i    (bus_wdata),
        .flags_i    (flags),
        .clr_mask_o (clr_mask),
        .rdata_o    (bus_rdata)
    );

    for (genvar i = 0; i < NF; i++) begin : g_flag
        if (IMPL_MASK[i]) begin : g_impl
            usb_irq_flag u_flag (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (set_ev[i]),
                .clr_i  (clr_mask[i]),
                .flag_o (flags[i])
            );
        end else begin : g_none
            assign flags[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= |flags;
        end
    end

endmodule

// File: rtl/usb_ep_irq_status_chk.sv
module usb_ep_irq_status_chk #(
    parameter int unsigned   NF       = 8,
    parameter int unsigned   AW       = 8,
    parameter logic [AW-1:0] REG_ADDR = '0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [AW-1:0] bus_addr,
    input logic [NF-1:0] bus_wdata,
    input logic [NF-1:0] bus_rdata,
    input logic          irq,
    input logic [NF-1:0] flags,
    input logic [NF-1:0] set_ev
);

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_ev) |=> ((flags & $past(set_ev)) == $past(set_ev))); // R9

    AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & ~$past(flags) & ~$past(set_ev)) == '0)); // R7

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_ADDR)
        |=> ((flags & $past(bus_wdata) & ~$past(set_ev)) == '0)); // R7

    AST_OTHER_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != REG_ADDR && set_ev == '0) |=> $stable(flags)); // R8

    AST_READ_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == REG_ADDR) |=> (bus_rdata == $past(flags))); // R11

    AST_BIT1_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> (bus_rdata[1] == 1'b0)); // R6

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (|flags) |=> irq); // R10

    AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == '0) |=> !irq); // R10

endmodule

bind usb_ep_irq_status usb_ep_irq_status_chk #(
    .NF       (NF),
    .AW       (AW),
    .REG_ADDR (REG_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .flags     (flags),
    .set_ev    (set_ev)
);

// File: tb/usb_ep_irq_status_test.sv
`timescale 1ns/1ps
module usb_ep_irq_status_test;

    localparam logic [7:0] ADDR = 8'h52;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;
    logic       ep0_rx_done = 1'b0;
    logic       ep0_tx_done = 1'b0;
    logic       ep0_data_end = 1'b0;
    logic       ep0_stall = 1'b0;
    logic       ep0_setup_end = 1'b0;
    logic [2:0] ep_tx_done = '0;
    logic [2:0] ep_rx_done = '0;
    logic [2:0] ep_underrun = '0;
    logic [2:0] ep_overrun = '0;
    logic [2:0] ep_stall = '0;

    int  tests = 0;
    int  fails = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    usb_ep_irq_status uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_wr        (bus_wr),
        .bus_rd        (bus_rd),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .irq           (irq),
        .ep0_rx_done   (ep0_rx_done),
        .ep0_tx_done   (ep0_tx_done),
        .ep0_data_end  (ep0_data_end),
        .ep0_stall     (ep0_stall),
        .ep0_setup_end (ep0_setup_end),
        .ep_tx_done    (ep_tx_done),
        .ep_rx_done    (ep_rx_done),
        .ep_underrun   (ep_underrun),
        .ep_overrun    (ep_overrun),
        .ep_stall      (ep_stall)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic read_reg(input logic [7:0] a, output logic [7:0] v);
        bus_rd = 1'b1; bus_addr = a;
        tick();
        bus_rd = 1'b0; bus_addr = 8'h00;
        v = bus_rdata;
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00;
    endtask

    // Sources 0..4: ep0 rx, tx, data-end, stall, setup-end.
    // Sources 5..19: per endpoint e: tx, underrun, rx, overrun, stall.
    task automatic drive_src(input int s, input logic v);
        if (s == 0) ep0_rx_done = v;
        else if (s == 1) ep0_tx_done = v;
        else if (s == 2) ep0_data_end = v;
        else if (s == 3) ep0_stall = v;
        else if (s == 4) ep0_setup_end = v;
        else begin
            case ((s - 5) % 5)
                0: ep_tx_done[(s - 5) / 5]  = v;
                1: ep_underrun[(s - 5) / 5] = v;
                2: ep_rx_done[(s - 5) / 5]  = v;
                3: ep_overrun[(s - 5) / 5]  = v;
                default: ep_stall[(s - 5) / 5] = v;
            endcase
        end
    endtask

    function automatic int src_bit(input int s);
        if (s < 5) return 0;
        return (((s - 5) % 5) < 2) ? 2 + 2 * ((s - 5) / 5) : 3 + 2 * ((s - 5) / 5);
    endfunction

    function automatic bit src_pulse(input int s);
        return (s == 0) || (s == 1) || (s >= 5 && (((s - 5) % 5) == 0 || ((s - 5) % 5) == 2));
    endfunction

    function automatic string src_req(input int s);
        if (s < 5) return "R2";
        return (((s - 5) % 5) < 2) ? "R3" : "R4";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] v2;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        chk("R1 rdata after reset", bus_rdata, 8'h00);
        chk("R1 irq after reset", {7'b0, irq}, 8'h00);
        read_reg(ADDR, v);
        chk("R1 flags after reset", v, 8'h00);

        // Sweep every trigger source of every flag.
        for (int s = 0; s < 20; s++) begin
            logic [7:0] exp_bits;
            exp_bits = 8'h01 << src_bit(s);
            if (src_pulse(s)) begin
                drive_src(s, 1'b1);
                tick();
                drive_src(s, 1'b0);
            end else if (s == 2) begin
                drive_src(s, 1'b1);
                tick();
                read_reg(ADDR, v);
                chk("R5 data-end rising ignored", v, 8'h00);
                drive_src(s, 1'b0);
                tick();
            end else begin
                drive_src(s, 1'b1);
                tick();
            end
            // R12: flag set at the edge that sampled the event; irq one edge later (R10)
            chk("R10 irq not yet up", {7'b0, irq}, 8'h00);
            read_reg(ADDR, v);
            chk({src_req(s), " R12 flag set"}, v, exp_bits);
            chk("R10 irq up one cycle later", {7'b0, irq}, 8'h01);
            write_reg(ADDR, 8'hFF);
            repeat (2) tick();
            read_reg(ADDR, v);
            chk("R5 R7 cleared, held level no retrigger", v, 8'h00);
            chk("R10 irq down after clear", {7'b0, irq}, 8'h00);
            if (!src_pulse(s) && s != 2) begin
                drive_src(s, 1'b0);
                tick();
                read_reg(ADDR, v);
                chk("R5 falling level ignored", v, 8'h00);
            end
        end

        // R6 and R7: writes never set anything
        write_reg(ADDR, 8'hFF);
        read_reg(ADDR, v);
        chk("R7 R6 write ones to empty register", v, 8'h00);

        // R7: zero bits keep flags
        ep0_rx_done = 1'b1; tick(); ep0_rx_done = 1'b0;
        write_reg(ADDR, 8'h00);
        read_reg(ADDR, v);
        chk("R7 write zero keeps flag", v, 8'h01);
        write_reg(ADDR, 8'hFE);
        read_reg(ADDR, v);
        chk("R7 write other bits keeps flag", v, 8'h01);

        // R8: other addresses ignored
        write_reg(8'h53, 8'hFF);
        read_reg(ADDR, v);
        chk("R8 write elsewhere ignored", v, 8'h01);
        read_reg(8'h51, v);
        chk("R8 read elsewhere returns 0", v, 8'h00);

        // R11: read has no side effect; rdata returns to 0
        read_reg(ADDR, v);
        read_reg(ADDR, v2);
        chk("R11 repeat read same", v2, v);
        tick();
        chk("R11 rdata idle zero", bus_rdata, 8'h00);

        // R9: set wins over clear in the same cycle
        ep_rx_done[0] = 1'b1; tick(); ep_rx_done[0] = 1'b0;
        read_reg(ADDR, v);
        chk("R4 ep1 out set", v, 8'h09);
        bus_wr = 1'b1; bus_addr = ADDR; bus_wdata = 8'hFF;
        ep_rx_done[0] = 1'b1; ep_tx_done[0] = 1'b1;
        tick();
        bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00;
        ep_rx_done[0] = 1'b0; ep_tx_done[0] = 1'b0;
        read_reg(ADDR, v);
        chk("R9 set beats clear", v, 8'h0C);

        // R10: irq stays while any flag remains
        write_reg(ADDR, 8'h04);
        tick();
        read_reg(ADDR, v);
        chk("R7 partial clear", v, 8'h08);
        chk("R10 irq held with one flag", {7'b0, irq}, 8'h01);
        write_reg(ADDR, 8'h08);
        tick();
        chk("R10 irq dropped", {7'b0, irq}, 8'h00);

        // R6: bit 1 with all sources firing at once
        ep0_tx_done = 1'b1; ep_tx_done = 3'b111; ep_rx_done = 3'b111;
        tick();
        ep0_tx_done = 1'b0; ep_tx_done = '0; ep_rx_done = '0;
        read_reg(ADDR, v);
        chk("R6 R2 R3 R4 all flags", v, 8'hFD);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule